// File: doc/BRIEF.md
# Stereo 24-bit Serial Audio Transmitter

This block sends stereo audio samples out on a single serial data line. Each channel word is 24 bits of two's-complement data, sent most significant bit first, inside a 32-bit channel slot of a 64-bit-clock frame. The bit clock and the frame clock come in as inputs that are synchronous to the system clock. They may be produced by a clock generator elsewhere on the chip or received from a pad after resynchronisation. The block watches for falling edges of the bit clock and changes the data line only there, so the data is steady around each rising edge.

Two framings are supported: I2S and left-justified. The block does not drive the data pin while it is in reset. The board pulls that pin high or low, and the level seen just after reset release selects the framing until the next reset. A new left/right pair is taken at the start of every frame, where the start of a frame is the frame-clock edge into the left channel. If no new pair has arrived since the last frame start, the previous pair is sent again.

Top module: `serial_audio_tx`

## Requirements
- R1: While reset is asserted, and on the first cycles after its synchronised release, `sd_oe` is 0. Once the format has been sampled, `sd_oe` goes to 1 and stays at 1 until the next reset.
- R2: The level of `sd_i` on the first cycle after the synchronised reset release selects the format: 1 selects I2S and 0 selects left-justified. The format then holds until the next reset.
- R3: Slot position 0 is the first bit clock after a frame-clock edge. In left-justified format, bit 23 of the word is sent at position 0. In I2S format, position 0 carries a zero and bit 23 is sent at position 1.
- R4: Data bits go out from bit 23 down to bit 0 on consecutive bit clocks. Every remaining position of the 32-bit slot carries 0.
- R5: In I2S format the left word is sent while `lrck_i` is 0. In left-justified format the left word is sent while `lrck_i` is 1.
- R6: `sd_o` changes only in the cycle after a falling edge of `bclk_i` is sampled. That falling edge is `bclk_i` going from 1 to 0 between two consecutive system clocks.
- R7: A pair strobed by `in_valid` is used from the next frame start onward. A strobe in the middle of a frame does not change the frame in progress. If several strobes arrive within one frame, the last one wins.
- R8: If no strobe arrived since the previous frame start, the previous pair is sent again. After reset the pair is all zeros.
- R9: After reset, `sd_o` stays 0 until the first frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe: a new sample pair is present |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| bclk_i | input | 1 | Bit clock, synchronous to clk |
| lrck_i | input | 1 | Frame clock, changes together with a bit-clock falling edge |
| sd_i | input | 1 | Level sensed on the data pin, used for the format strap |
| sd_o | output | 1 | Serial data out |
| sd_oe | output | 1 | Output enable for the data pin |

## Verification
The main function is driven with pairs whose left and right words differ, with the extreme codes 0x800000 and 0x7FFFFF, and with mixed bit patterns. The extreme codes and the mixed patterns show whether the first data position is off by one and whether the two channels are swapped. The same stimulus is run in both strap settings, so a format that was latched wrongly shows up as a one-bit shift and an inverted channel level. Frames with no strobe, with a strobe early in the slot, and with two strobes separate the repeat rule, the frame-boundary capture and the last-one-wins rule. Bit clocks before the first frame edge, together with a second reset in the middle of a run, check the zero output before the first frame and that the strap is sampled again.

// File: rtl/sap_pkg.sv
package sap_pkg;
  typedef enum logic {
    FMT_LEFT = 1'b0,
    FMT_I2S  = 1'b1
  } fmt_e;
endpackage

// File: rtl/sap_strap.sv
module sap_strap
  import sap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rst_sync_n,
  output logic run_o,
  output fmt_e fmt_o
);
  logic [1:0] sync_q;
  logic       run_q, run_d;
  fmt_e       fmt_q, fmt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  always_comb begin
    run_d = 1'b1;
    fmt_d = run_q ? fmt_q : fmt_e'(pin_i);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q <= 1'b0;
      fmt_q <= FMT_LEFT;
    end else begin
      run_q <= run_d;
      fmt_q <= fmt_d;
    end
  end

  assign run_o = run_q;
  assign fmt_o = fmt_q;

  // R1
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run_q |=> run_q);
  // R2
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run_q |=> $stable(fmt_q));
endmodule

// File: rtl/sap_framer.sv
module sap_framer
  import sap_pkg::*;
#(
  parameter int SLOT_W = 32,
  localparam int POS_W = $clog2(SLOT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  fmt_e             fmt_i,
  input  logic             bclk_i,
  input  logic             lrck_i,
  output logic             bfall_o,
  output logic             frame_start_o,
  output logic [POS_W-1:0] pos_o,
  output logic             left_o,
  output logic             synced_o
);
  logic             bclk_q, lrck_q, synced_q, synced_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             bfall, lr_edge, left_now, fstart;

  always_comb begin
    bfall    = run_i & bclk_q & ~bclk_i;
    lr_edge  = bfall & (lrck_i ^ lrck_q);
    left_now = (fmt_i == FMT_I2S) ? ~lrck_i : lrck_i;
    fstart   = lr_edge & left_now;
    pos_d    = pos_q;
    if (bfall) pos_d = lr_edge ? '0 : pos_q + 1'b1;
    synced_d = synced_q | fstart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q   <= 1'b1;
      lrck_q   <= 1'b0;
      pos_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      bclk_q   <= bclk_i;
      lrck_q   <= lrck_i;
      pos_q    <= pos_d;
      synced_q <= synced_d;
    end
  end

  assign bfall_o       = bfall;
  assign frame_start_o = fstart;
  assign pos_o         = pos_d;
  assign left_o        = left_now;
  assign synced_o      = synced_d;

  // R9
  synced_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    synced_q |=> synced_q);
endmodule

// File: rtl/sap_loader.sv
module sap_loader #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                frame_start_i,
  output logic [SAMPLE_W-1:0] word_l_o,
  output logic [SAMPLE_W-1:0] word_r_o
);
  logic [SAMPLE_W-1:0] pend_l_q, pend_r_q, cur_l_q, cur_r_q;
  logic [SAMPLE_W-1:0] pend_l_d, pend_r_d, cur_l_d, cur_r_d;
  logic                pend_v_q, pend_v_d, load;

  always_comb begin
    load     = frame_start_i & pend_v_q;
    cur_l_d  = load ? pend_l_q : cur_l_q;
    cur_r_d  = load ? pend_r_q : cur_r_q;
    pend_l_d = in_valid ? in_left  : pend_l_q;
    pend_r_d = in_valid ? in_right : pend_r_q;
    pend_v_d = in_valid | (pend_v_q & ~load);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l_q <= '0;
      pend_r_q <= '0;
      pend_v_q <= 1'b0;
      cur_l_q  <= '0;
      cur_r_q  <= '0;
    end else begin
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
      pend_v_q <= pend_v_d;
      cur_l_q  <= cur_l_d;
      cur_r_q  <= cur_r_d;
    end
  end

  assign word_l_o = cur_l_d;
  assign word_r_o = cur_r_d;

  // R7
  // R8
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start_i || !pend_v_q) |=> ($stable(cur_l_q) && $stable(cur_r_q)));
endmodule

// File: rtl/sap_shifter.sv
module sap_shifter
  import sap_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  localparam int POS_W   = $clog2(SLOT_W),
  localparam int KW      = POS_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  fmt_e                fmt_i,
  input  logic                bfall_i,
  input  logic                synced_i,
  input  logic                left_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic [SAMPLE_W-1:0] word_l_i,
  input  logic [SAMPLE_W-1:0] word_r_i,
  output logic                sd_o
);
  logic [KW-1:0]       dly, k;
  logic [SAMPLE_W-1:0] word_sel, shifted;
  logic                bit_d, sd_q, sd_d;

  always_comb begin
    dly      = (fmt_i == FMT_I2S) ? KW'(1) : '0;
    k        = {1'b0, pos_i} - dly;
    word_sel = left_i ? word_l_i : word_r_i;
    shifted  = word_sel << k;
    bit_d    = 1'b0;
    if (synced_i && (k < KW'(SAMPLE_W))) bit_d = shifted[SAMPLE_W-1];
    sd_d     = bfall_i ? bit_d : sd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 1'b0;
    else        sd_q <= sd_d;
  end

  assign sd_o = sd_q;

  // R6
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bfall_i |=> $stable(sd_q));
  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bfall_i && ({1'b0, pos_i} >= KW'(SAMPLE_W + 1))) |=> !sd_q);
  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !synced_i |=> !sd_q);
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import sap_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  localparam int POS_W   = $clog2(SLOT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                bclk_i,
  input  logic                lrck_i,
  input  logic                sd_i,
  output logic                sd_o,
  output logic                sd_oe
);
  logic                rst_sync_n, run, bfall, fstart, left, synced;
  fmt_e                fmt;
  logic [POS_W-1:0]    pos;
  logic [SAMPLE_W-1:0] word_l, word_r;

  sap_strap u_strap (
    .clk(clk), .rst_n(rst_n), .pin_i(sd_i),
    .rst_sync_n(rst_sync_n), .run_o(run), .fmt_o(fmt)
  );

  sap_framer #(.SLOT_W(SLOT_W)) u_framer (
    .clk(clk), .rst_n(rst_sync_n), .run_i(run), .fmt_i(fmt),
    .bclk_i(bclk_i), .lrck_i(lrck_i), .bfall_o(bfall),
    .frame_start_o(fstart), .pos_o(pos), .left_o(left), .synced_o(synced)
  );

  sap_loader #(.SAMPLE_W(SAMPLE_W)) u_loader (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right), .frame_start_i(fstart),
    .word_l_o(word_l), .word_r_o(word_r)
  );

  sap_shifter #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_shifter (
    .clk(clk), .rst_n(rst_sync_n), .fmt_i(fmt), .bfall_i(bfall),
    .synced_i(synced), .left_i(left), .pos_i(pos),
    .word_l_i(word_l), .word_r_i(word_r), .sd_o(sd_o)
  );

  assign sd_oe = run;

  // R1
  oe_in_reset_chk: assert property (@(posedge clk) !rst_n |-> !sd_oe);
endmodule

// File: tb/serial_audio_tx_bench.sv
module serial_audio_tx_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, bclk, lrck, strap;
  logic [23:0] in_left, in_right;
  logic        sd_o, sd_oe;
  wire         sd_pin = sd_oe ? sd_o : strap;

  serial_audio_tx u_serial_audio_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .bclk_i(bclk), .lrck_i(lrck), .sd_i(sd_pin),
    .sd_o(sd_o), .sd_oe(sd_oe)
  );

  int          checks = 0, failures = 0;
  logic        exp_bit, exp_oe, i2s, sync_m;
  logic [23:0] cur_l, cur_r;
  logic [23:0] q_l[$], q_r[$];
  string       tag, frame_tag;
  int          pat_idx = 0;

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s t=%0t got %b exp %b", req, $time, got, exp);
    end
  endtask

  function automatic logic [23:0] pat(int i);
    case (i % 4)
      0: return 24'h800000;
      1: return 24'h7FFFFF;
      default: return 24'(i * 32'h0009E3B5 ^ 32'h00A5C35A);
    endcase
  endfunction

  // compare at the falling system-clock edge, then move on
  task automatic step;
    @(negedge clk);
    if (exp_oe) begin
      chk("R1 oe", sd_oe, 1'b1);
      chk(tag, sd_o, exp_bit);
    end
    tag = "R6 hold";
  endtask

  task automatic push(int id);
    in_valid = 1'b1;
    in_left  = pat(id);
    in_right = ~pat(id + 7);
    q_l.push_back(in_left);
    q_r.push_back(in_right);
  endtask

  // one bit-clock period (four system clocks); fall driven first
  task automatic bit_period(logic lr, int p, logic left, logic pre, int push_id);
    int k;
    logic [23:0] w;
    bclk = 1'b0;
    lrck = lr;
    if (push_id >= 0) push(push_id);
    k = p - (i2s ? 1 : 0);
    w = left ? cur_l : cur_r;
    exp_bit = (sync_m && k >= 0 && k < 24) ? w[23 - k] : 1'b0;
    if (pre || !sync_m)       tag = "R9 before first frame";
    else if (p <= 1)          tag = $sformatf("R2 R3 %s p=%0d", frame_tag, p);
    else if (k >= 24)         tag = $sformatf("R4 pad %s p=%0d", frame_tag, p);
    else                      tag = $sformatf("R5 R4 %s left=%0b p=%0d", frame_tag, left, p);
    step();
    in_valid = 1'b0;
    step();
    bclk = 1'b1;
    step();
    step();
  endtask

  task automatic run_phase(logic fmt, int frames);
    logic lv;
    strap = fmt; i2s = fmt; lv = fmt ? 1'b0 : 1'b1;
    rst_n = 1'b0; bclk = 1'b1; lrck = ~lv; in_valid = 1'b0;
    exp_oe = 1'b0; exp_bit = 1'b0; sync_m = 1'b0;
    cur_l = '0; cur_r = '0; q_l.delete(); q_r.delete();
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", sd_oe, 1'b0);
    chk("R2 strap visible on pin", sd_pin, fmt);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe just after release", sd_oe, 1'b0);
    repeat (7) @(negedge clk);
    chk("R1 oe after strap", sd_oe, 1'b1);
    chk("R9 idle output", sd_o, 1'b0);
    exp_oe = 1'b1;
    for (int b = 0; b < 5; b++) bit_period(~lv, 20 + b, 1'b0, 1'b1, -1);
    for (int f = 0; f < frames; f++) begin
      for (int n = 0; n < 64; n++) begin
        int pid;
        pid = -1;
        if (n == 0) begin
          sync_m = 1'b1;
          if (q_l.size() > 0) begin
            cur_l = q_l[$]; cur_r = q_r[$];
            q_l.delete(); q_r.delete();
            frame_tag = "R7 new pair";
          end else frame_tag = "R8 repeat";
        end
        case (f % 8)
          0, 5: if (n == 40) pid = pat_idx++;
          1:    if (n == 10) pid = pat_idx++;
          4:    if (n == 40 || n == 50) pid = pat_idx++;
          default: ;
        endcase
        bit_period((n < 32) ? lv : ~lv, n % 32, n < 32, 1'b0, pid);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tag = "R9"; frame_tag = "R8";
    in_left = '0; in_right = '0;
    run_phase(1'b1, 8);   // I2S
    run_phase(1'b0, 8);   // left-justified
    run_phase(1'b1, 3);   // reset again mid-run
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule